// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Register Front End

This block sits between a simple 32-bit register bus and the sequencer that drives a one-time-programmable fuse array. Software uses it to set the fuse timing, choose a word address, arm a program access with a key, and supply the program data. It can also ask for every shadow word to be refreshed from the fuses. The block holds a bank of shadow words, one per fuse word, that software reads through an address window. During a refresh, the sequencer fills this bank.

Protection is enforced here rather than in software. Every program access must be re-armed with a 16-bit key. A word marked program-locked by the lock input cannot be programmed, and its shadow cannot be overwritten. A word marked read-locked returns a poison pattern when read. Each violation raises a sticky error flag. While that flag is set, new accesses are refused until software clears it. Each accepted command sends a one-cycle start pulse to the sequencer. The block then stays busy until the sequencer returns a done pulse.

Top module: `fuse_regfront`

## Requirements
- R1: After reset, the control word (offset 0x00), the data register (0x20), the timing register (0x10), every shadow word and the read data are all zero, and `seq_start` is low.
- R2: The control word reads as {key[31:16], 0[15:11], refresh[10], error[9], busy[8], address[7:0]}. A write to 0x00 replaces the address and key fields. A write to 0x04 ORs the written 1s into them, and a write to 0x08 clears the matching bits. Reads of 0x04 and 0x08 return the control word.
- R3: A write to the data register is accepted as a program access when all of these hold at that moment: the key field equals 0x3E77, busy is clear and error is clear. One cycle later, `seq_start` is high for exactly one cycle with `seq_cmd`=0, `seq_addr` equal to the address field and `seq_wdata` equal to the written data. At the same time, busy is set and the key field is cleared.
- R4: A data write made with any other key stores the data but starts nothing and leaves busy clear.
- R5: `seq_addr` is captured when a program access is accepted. Writes to the address field while busy leave it unchanged.
- R6: Data writes while busy are ignored: the data register keeps its value and no start is issued.
- R7: An armed program access aimed at a program-locked word starts nothing, leaves busy clear, sets error and clears the key. Addresses at or above the word count are treated as locked.
- R8: Busy, and the refresh flag with it, clears on the clock edge where `seq_done` is high.
- R9: A read of a read-locked shadow word returns 0xBADABADA and sets error.
- R10: A bus write to a shadow word while a refresh is in progress, or to a program-locked word, sets error and leaves the shadow unchanged. Other shadow writes store the data.
- R11: While error is set, program and refresh requests are refused and shadow reads return 0. Writing a 1 to bit 9 of offset 0x08 clears error.
- R12: Writing a 1 to bit 10 through 0x00 or 0x04, while idle and without error, sets busy and refresh and issues a start with `seq_cmd`=1. Fill writes update shadows only while refresh is set.
- R13: Shadow word n sits at byte offset 0x400 + 16·n for n below 128. The timing register value is driven on `timing_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe |
| reg_addr | input | 12 | Bus byte address |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| prog_lock | input | 128 | Per-word program lock |
| read_lock | input | 128 | Per-word read lock |
| timing_cfg | output | 32 | Timing register contents for the sequencer |
| seq_start | output | 1 | One-cycle command pulse |
| seq_cmd | output | 1 | 0 = program, 1 = refresh |
| seq_addr | output | 8 | Captured word address of a program |
| seq_wdata | output | 32 | Program data |
| seq_done | input | 1 | Sequencer completion pulse |
| fill_we | input | 1 | Shadow fill strobe during refresh |
| fill_idx | input | 7 | Shadow word being filled |
| fill_data | input | 32 | Fill data |

## Verification
Register updates, the error flag and the start pulse all appear one clock edge after the strobe that causes them. The bench therefore drives each strobe for a single cycle from one falling edge and samples at the next falling edge. Read data is registered, so a read strobed in one cycle is compared at the following falling edge. This means a control word read in the same cycle as `seq_done` still shows busy set, and the next read shows it clear; the bench checks both values. Start counts are compared two cycles after the stimulus, once any pulse has certainly been seen.

// File: rtl/fuse_pkg.sv
// Shared constants and command encoding for the fuse register front end.
// Assumes a 32-bit register bus and an 8-bit word address field.
package fuse_pkg;
    localparam int          ADDR_W     = 8;
    localparam int          KEY_LSB    = 16;
    localparam int          BIT_BUSY   = 8;
    localparam int          BIT_ERR    = 9;
    localparam int          BIT_RELOAD = 10;
    localparam int          STRIDE_LG2 = 4;
    localparam logic [15:0] ARM_KEY    = 16'h3E77;
    localparam logic [31:0] POISON     = 32'hBADA_BADA;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_SET  = 'h04;
    localparam int OFS_CLR  = 'h08;
    localparam int OFS_TIM  = 'h10;
    localparam int OFS_DATA = 'h20;

    typedef enum logic {
        CMD_PROG   = 1'b0,
        CMD_RELOAD = 1'b1
    } seq_cmd_e;
endpackage

// File: rtl/fuse_addr_dec.sv
// Address decoder: turns a bus byte address into one-hot register selects
// and a shadow word index. Assumes shadow words are 16 bytes apart.
module fuse_addr_dec
    import fuse_pkg::*;
#(
    parameter int  NWORDS      = 128,
    parameter int  AW          = 12,
    parameter int  SHADOW_BASE = 'h400,
    localparam int IDXW        = $clog2(NWORDS)
)(
    input  logic [AW-1:0]   addr,
    output logic            sel_ctrl,
    output logic            sel_set,
    output logic            sel_clr,
    output logic            sel_tim,
    output logic            sel_data,
    output logic            sel_shadow,
    output logic [IDXW-1:0] sh_idx
);
    localparam logic [AW-1:0] BASE_A = AW'(SHADOW_BASE);

    logic [AW-1:0] off;

    // Fixed register selects.
    always_comb begin
        sel_ctrl = (addr == AW'(OFS_CTRL));
        sel_set  = (addr == AW'(OFS_SET));
        sel_clr  = (addr == AW'(OFS_CLR));
        sel_tim  = (addr == AW'(OFS_TIM));
        sel_data = (addr == AW'(OFS_DATA));
    end

    // Shadow window hit and word index.
    always_comb begin
        off        = addr - BASE_A;
        sel_shadow = (addr >= BASE_A) && (off[STRIDE_LG2-1:0] == '0)
                     && (int'(off >> STRIDE_LG2) < NWORDS);
        sh_idx     = off[STRIDE_LG2 +: IDXW];
    end
endmodule

// File: rtl/fuse_ctrl_core.sv
// Control core: holds the address and key fields, the busy, error and
// refresh flags, and the timing and data registers. It also issues
// commands to the sequencer. Assumes one bus access per cycle.
module fuse_ctrl_core
    import fuse_pkg::*;
#(
    parameter int  NWORDS = 128,
    localparam int IDXW   = $clog2(NWORDS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic              wr_tim,
    input  logic              wr_data,
    input  logic [31:0]       wdata,
    input  logic [NWORDS-1:0] prog_lock,
    input  logic              shadow_err,
    input  logic              seq_done,
    output logic [31:0]       ctrl_word,
    output logic [31:0]       timing_q,
    output logic [31:0]       data_q,
    output logic              busy,
    output logic              err_flag,
    output logic              reload_act,
    output logic [15:0]       key_fld,
    output logic [ADDR_W-1:0] addr_fld,
    output logic              seq_start,
    output logic              seq_cmd,
    output logic [ADDR_W-1:0] seq_addr
);
    logic [15:0]       key_n;
    logic [ADDR_W-1:0] addr_n;
    logic              reload_req, err_clr, idle_ok, lock_hit;
    logic              prog_try, prog_go, prog_deny, rel_go, finish;

    // Decide the next field values and which commands are accepted.
    always_comb begin
        addr_n = addr_fld;
        key_n  = key_fld;
        if (wr_ctrl) begin
            addr_n = wdata[ADDR_W-1:0];
            key_n  = wdata[KEY_LSB +: 16];
        end
        if (wr_set) begin
            addr_n = addr_n | wdata[ADDR_W-1:0];
            key_n  = key_n  | wdata[KEY_LSB +: 16];
        end
        if (wr_clr) begin
            addr_n = addr_n & ~wdata[ADDR_W-1:0];
            key_n  = key_n  & ~wdata[KEY_LSB +: 16];
        end
        reload_req = (wr_ctrl || wr_set) && wdata[BIT_RELOAD];
        err_clr    = wr_clr && wdata[BIT_ERR];
        idle_ok    = !busy && !err_flag;
        lock_hit   = (int'(addr_fld) >= NWORDS) || prog_lock[addr_fld[IDXW-1:0]];
        prog_try   = wr_data && idle_ok && (key_fld == ARM_KEY);
        prog_go    = prog_try && !lock_hit;
        prog_deny  = prog_try && lock_hit;
        rel_go     = reload_req && idle_ok && !prog_try;
        finish     = busy && seq_done;
        if (prog_try) key_n = '0;
    end

    // Address and key fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_fld <= '0;
            key_fld  <= '0;
        end else begin
            addr_fld <= addr_n;
            key_fld  <= key_n;
        end
    end

    // Busy and refresh flags: set by an accepted command, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            reload_act <= 1'b0;
        end else if (prog_go || rel_go) begin
            busy       <= 1'b1;
            reload_act <= rel_go;
        end else if (finish) begin
            busy       <= 1'b0;
            reload_act <= 1'b0;
        end
    end

    // Sticky error flag: a new violation wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                       err_flag <= 1'b0;
        else if (prog_deny || shadow_err) err_flag <= 1'b1;
        else if (err_clr)                 err_flag <= 1'b0;
    end

    // Timing register.
    always_ff @(posedge clk) begin
        if (!rst_n)      timing_q <= '0;
        else if (wr_tim) timing_q <= wdata;
    end

    // Data register: frozen while a command is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (wr_data && !busy)  data_q <= wdata;
    end

    // Sequencer command pulse, type and captured word address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_start <= 1'b0;
            seq_cmd   <= CMD_PROG;
            seq_addr  <= '0;
        end else begin
            seq_start <= prog_go || rel_go;
            if (prog_go) begin
                seq_cmd  <= CMD_PROG;
                seq_addr <= addr_fld;
            end else if (rel_go) begin
                seq_cmd  <= CMD_RELOAD;
            end
        end
    end

    // Assemble the readable control word.
    always_comb begin
        ctrl_word                   = '0;
        ctrl_word[ADDR_W-1:0]       = addr_fld;
        ctrl_word[BIT_BUSY]         = busy;
        ctrl_word[BIT_ERR]          = err_flag;
        ctrl_word[BIT_RELOAD]       = reload_act;
        ctrl_word[KEY_LSB +: 16]    = key_fld;
    end
endmodule

// File: rtl/fuse_shadow_bank.sv
// Shadow word bank: holds one copy of each fuse word. It is filled by the
// sequencer during a refresh and can be written over the bus when allowed.
// It checks the lock rules for bus reads and writes. Assumes fill indices
// stay below NWORDS.
module fuse_shadow_bank
    import fuse_pkg::*;
#(
    parameter int  NWORDS = 128,
    localparam int IDXW   = $clog2(NWORDS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sh,
    input  logic              rd_sh,
    input  logic [IDXW-1:0]   idx,
    input  logic [31:0]       wdata,
    input  logic              reload_act,
    input  logic              err_flag,
    input  logic [NWORDS-1:0] prog_lock,
    input  logic [NWORDS-1:0] read_lock,
    input  logic              fill_we,
    input  logic [IDXW-1:0]   fill_idx,
    input  logic [31:0]       fill_data,
    output logic [31:0]       rd_val,
    output logic              err_evt
);
    logic [31:0] words [NWORDS];
    logic        wr_bad, rd_bad, wr_ok;

    // Lock rule evaluation for the current bus access.
    always_comb begin
        wr_bad  = wr_sh && (reload_act || prog_lock[idx]);
        wr_ok   = wr_sh && !reload_act && !prog_lock[idx];
        rd_bad  = rd_sh && !err_flag && read_lock[idx];
        err_evt = wr_bad || rd_bad;
    end

    // Per-word storage: a refresh fill takes priority over a bus write.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= '0;
            else if (reload_act && fill_we && (fill_idx == IDXW'(w)))
                words[w] <= fill_data;
            else if (wr_ok && (idx == IDXW'(w)))
                words[w] <= wdata;
        end
    end

    // Read value: refused under error, poisoned when read-locked.
    always_comb begin
        if (err_flag)            rd_val = '0;
        else if (read_lock[idx]) rd_val = POISON;
        else                     rd_val = words[idx];
    end
endmodule

// File: rtl/fuse_regfront.sv
// Top of the fuse register front end. It decodes bus accesses, routes them
// to the control core and the shadow bank, and registers read data.
// Assumes reg_wr and reg_rd are single-cycle strobes.
module fuse_regfront
    import fuse_pkg::*;
#(
    parameter int  NWORDS      = 128,
    parameter int  AW          = 12,
    parameter int  SHADOW_BASE = 'h400,
    localparam int IDXW        = $clog2(NWORDS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NWORDS-1:0] prog_lock,
    input  logic [NWORDS-1:0] read_lock,
    output logic [31:0]       timing_cfg,
    output logic              seq_start,
    output logic              seq_cmd,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [31:0]       seq_wdata,
    input  logic              seq_done,
    input  logic              fill_we,
    input  logic [IDXW-1:0]   fill_idx,
    input  logic [31:0]       fill_data
);
    logic              sel_ctrl, sel_set, sel_clr, sel_tim, sel_data, sel_shadow;
    logic [IDXW-1:0]   sh_idx;
    logic [31:0]       ctrl_word, timing_q, data_q, sh_val;
    logic              busy, err_flag, reload_act, shadow_err;
    logic [15:0]       key_fld;
    logic [ADDR_W-1:0] addr_fld;

    fuse_addr_dec #(.NWORDS(NWORDS), .AW(AW), .SHADOW_BASE(SHADOW_BASE)) u_dec (
        .addr(reg_addr), .sel_ctrl(sel_ctrl), .sel_set(sel_set), .sel_clr(sel_clr),
        .sel_tim(sel_tim), .sel_data(sel_data), .sel_shadow(sel_shadow), .sh_idx(sh_idx)
    );

    fuse_ctrl_core #(.NWORDS(NWORDS)) u_core (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(reg_wr && sel_ctrl), .wr_set(reg_wr && sel_set),
        .wr_clr(reg_wr && sel_clr), .wr_tim(reg_wr && sel_tim),
        .wr_data(reg_wr && sel_data), .wdata(reg_wdata),
        .prog_lock(prog_lock), .shadow_err(shadow_err), .seq_done(seq_done),
        .ctrl_word(ctrl_word), .timing_q(timing_q), .data_q(data_q),
        .busy(busy), .err_flag(err_flag), .reload_act(reload_act),
        .key_fld(key_fld), .addr_fld(addr_fld),
        .seq_start(seq_start), .seq_cmd(seq_cmd), .seq_addr(seq_addr)
    );

    fuse_shadow_bank #(.NWORDS(NWORDS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_sh(reg_wr && sel_shadow), .rd_sh(reg_rd && sel_shadow),
        .idx(sh_idx), .wdata(reg_wdata), .reload_act(reload_act),
        .err_flag(err_flag), .prog_lock(prog_lock), .read_lock(read_lock),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data),
        .rd_val(sh_val), .err_evt(shadow_err)
    );

    assign timing_cfg = timing_q;
    assign seq_wdata  = data_q;

    // Registered read data mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (sel_ctrl || sel_set || sel_clr) reg_rdata <= ctrl_word;
            else if (sel_tim)                   reg_rdata <= timing_q;
            else if (sel_data)                  reg_rdata <= data_q;
            else if (sel_shadow)                reg_rdata <= sh_val;
            else                                reg_rdata <= '0;
        end
    end
endmodule

// File: rtl/fuse_regfront_chk.sv
// Property checker for the fuse register front end, attached by bind.
// Decodes the bus independently of the design to form its conditions.
module fuse_regfront_chk
    import fuse_pkg::*;
#(
    parameter int  NWORDS      = 128,
    parameter int  AW          = 12,
    parameter int  SHADOW_BASE = 'h400,
    localparam int IDXW        = $clog2(NWORDS)
)(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [AW-1:0]     reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [NWORDS-1:0] prog_lock,
    input logic [NWORDS-1:0] read_lock,
    input logic              seq_start,
    input logic              seq_done,
    input logic [ADDR_W-1:0] seq_addr,
    input logic              busy,
    input logic              err_flag,
    input logic [15:0]       key_fld,
    input logic [ADDR_W-1:0] addr_fld
);
    logic [AW-1:0]   c_off;
    logic            c_sh_hit, c_lock, c_armed;
    logic [IDXW-1:0] c_idx;

    // Independent decode of the bus access.
    always_comb begin
        c_off    = reg_addr - AW'(SHADOW_BASE);
        c_idx    = c_off[4 +: IDXW];
        c_sh_hit = (reg_addr >= AW'(SHADOW_BASE)) && (c_off[3:0] == 4'h0)
                   && (int'(c_off >> 4) < NWORDS);
        c_lock   = (int'(addr_fld) >= NWORDS) || prog_lock[addr_fld[IDXW-1:0]];
        c_armed  = reg_wr && (reg_addr == AW'(OFS_DATA)) && !busy && !err_flag
                   && (key_fld == ARM_KEY);
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start); // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> busy); // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done) |=> $stable(seq_addr)); // R5
    AST_LOCKED_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (c_armed && c_lock) |=> (!seq_start && !busy && err_flag)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_done) |=> !busy); // R8
    AST_POISON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && c_sh_hit && !err_flag && read_lock[c_idx])
        |=> (reg_rdata == POISON && err_flag)); // R9
    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !seq_start); // R11
endmodule

bind fuse_regfront fuse_regfront_chk #(
    .NWORDS(NWORDS), .AW(AW), .SHADOW_BASE(SHADOW_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .prog_lock(prog_lock),
    .read_lock(read_lock), .seq_start(seq_start), .seq_done(seq_done),
    .seq_addr(seq_addr), .busy(busy), .err_flag(err_flag),
    .key_fld(key_fld), .addr_fld(addr_fld)
);

// File: tb/tb_fuse_regfront.sv
// Self-checking bench: a behavioural sequencer model, directed corner cases
// and seeded random program/readback rounds.
module tb_fuse_regfront;
    localparam int CLK_NS = 10;
    localparam int NW     = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NW-1:0] prog_lock, read_lock;
    logic [31:0] timing_cfg, seq_wdata;
    logic        seq_start, seq_cmd, seq_done;
    logic [7:0]  seq_addr;
    logic        fill_we;
    logic [6:0]  fill_idx;
    logic [31:0] fill_data;

    int total = 0, bad = 0, start_cnt = 0, done_wait = 20;
    logic [31:0] fuse [NW];
    logic [31:0] exp_fuse [NW];

    always #(CLK_NS/2) clk = ~clk;

    fuse_regfront dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .prog_lock(prog_lock), .read_lock(read_lock), .timing_cfg(timing_cfg),
        .seq_start(seq_start), .seq_cmd(seq_cmd), .seq_addr(seq_addr),
        .seq_wdata(seq_wdata), .seq_done(seq_done), .fill_we(fill_we),
        .fill_idx(fill_idx), .fill_data(fill_data)
    );

    function automatic logic [31:0] cw(logic [15:0] k, logic rl, logic er, logic bz, logic [7:0] a);
        return {k, 5'b0, rl, er, bz, a};
    endfunction

    function automatic logic [11:0] sh(int n);
        return 12'(32'h400 + n * 16);
    endfunction

    function automatic logic [31:0] init_fuse(int n);
        return (32'(n) * 32'h0101_0101) ^ 32'h5A5A_0000;
    endfunction

    function automatic bit locked_any(int n);
        return prog_lock[n] || read_lock[n];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // Wait for done, read control in that cycle and the next.
    task automatic done_check(string req, logic [31:0] e1, logic [31:0] e2);
        logic [31:0] v;
        wait (seq_done === 1'b1);
        reg_rd = 1'b1; reg_addr = 12'h000;
        @(negedge clk);
        v = reg_rdata;
        chk(req, v, e1);
        @(negedge clk);
        reg_rd = 1'b0;
        chk(req, reg_rdata, e2);
    endtask

    // Behavioural sequencer: programs OR into fuses, refresh fills all shadows.
    initial begin
        logic cmd; logic [7:0] a; logic [31:0] d;
        seq_done = 1'b0; fill_we = 1'b0; fill_idx = '0; fill_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n && seq_start) begin
                cmd = seq_cmd; a = seq_addr; d = seq_wdata;
                start_cnt++;
                repeat (done_wait) @(negedge clk);
                if (cmd) begin
                    for (int i = 0; i < NW; i++) begin
                        fill_we = 1'b1; fill_idx = 7'(i); fill_data = fuse[i];
                        @(negedge clk);
                    end
                    fill_we = 1'b0;
                end else if (a < 8'(NW)) begin
                    fuse[a] = fuse[a] | d;
                end
                seq_done = 1'b1;
                @(negedge clk);
                seq_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R8 act=%0d exp=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, d, d2, tv;
        int n, sc;
        v = $urandom(32'd4242);
        prog_lock = '0; read_lock = '0;
        prog_lock[5] = 1'b1; prog_lock[100] = 1'b1;
        read_lock[7] = 1'b1; read_lock[64] = 1'b1;
        for (int i = 0; i < NW; i++) begin
            fuse[i] = init_fuse(i);
            exp_fuse[i] = init_fuse(i);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 start", {31'b0, seq_start}, 32'h0);
        bus_rd(12'h000, v); chk("R1 ctrl", v, 32'h0);
        bus_rd(12'h020, v); chk("R1 data", v, 32'h0);
        bus_rd(12'h010, v); chk("R1 timing", v, 32'h0);
        bus_rd(sh(0), v);   chk("R1 shadow", v, 32'h0);

        // R13 timing register
        tv = $urandom;
        bus_wr(12'h010, tv);
        bus_rd(12'h010, v); chk("R13 timing rd", v, tv);
        chk("R13 timing out", timing_cfg, tv);

        // R2 control write, set and clear aliases
        bus_wr(12'h000, 32'hABCD_0012);
        bus_rd(12'h000, v); chk("R2 ctrl wr", v, cw(16'hABCD, 0, 0, 0, 8'h12));
        bus_wr(12'h004, 32'h0000_0021);
        bus_rd(12'h004, v); chk("R2 set", v, cw(16'hABCD, 0, 0, 0, 8'h33));
        bus_wr(12'h008, 32'hFFFF_0003);
        bus_rd(12'h008, v); chk("R2 clr", v, cw(16'h0, 0, 0, 0, 8'h30));

        // R13/R10 random shadow writes to unlocked words
        for (int k = 0; k < 16; k++) begin
            do n = $urandom_range(0, NW-1); while (locked_any(n));
            d = $urandom;
            bus_wr(sh(n), d);
            bus_rd(sh(n), v); chk("R13 shadow rw", v, d);
        end

        // R4 wrong key
        sc = start_cnt;
        bus_wr(12'h000, 32'h1234_0003);
        d = $urandom;
        bus_wr(12'h020, d);
        chk("R4 no start", {31'b0, seq_start}, 32'h0);
        repeat (2) @(negedge clk); #1;
        chk("R4 cnt", 32'(start_cnt), 32'(sc));
        bus_rd(12'h000, v); chk("R4 ctrl", v, cw(16'h1234, 0, 0, 0, 8'h03));
        bus_rd(12'h020, v); chk("R4 data", v, d);

        // R3 accepted program, R5 address held, R6 data frozen, R8 done
        done_wait = 20;
        bus_wr(12'h000, 32'h3E77_000A);
        d = $urandom; d2 = ~d;
        bus_wr(12'h020, d);
        chk("R3 start", {31'b0, seq_start}, 32'h1);
        chk("R3 cmd", {31'b0, seq_cmd}, 32'h0);
        chk("R3 addr", {24'b0, seq_addr}, 32'h0A);
        chk("R3 wdata", seq_wdata, d);
        bus_rd(12'h000, v); chk("R3 busy key", v, cw(16'h0, 0, 0, 1, 8'h0A));
        bus_wr(12'h000, 32'h0000_0055);
        chk("R5 held", {24'b0, seq_addr}, 32'h0A);
        sc = start_cnt;
        bus_wr(12'h020, d2);
        bus_rd(12'h020, v); chk("R6 data", v, d);
        chk("R6 cnt", 32'(start_cnt), 32'(sc));
        exp_fuse[10] = exp_fuse[10] | d;
        done_check("R8 done", cw(16'h0, 0, 0, 1, 8'h55), cw(16'h0, 0, 0, 0, 8'h55));

        // R7 locked word and out-of-range address
        bus_wr(12'h000, 32'h3E77_0005);
        bus_wr(12'h020, 32'h1);
        chk("R7 no start", {31'b0, seq_start}, 32'h0);
        bus_rd(12'h000, v); chk("R7 ctrl", v, cw(16'h0, 0, 1, 0, 8'h05));
        bus_wr(12'h008, 32'h0000_0200);
        bus_wr(12'h000, 32'h3E77_00C8);
        bus_wr(12'h020, 32'h1);
        chk("R7 range no start", {31'b0, seq_start}, 32'h0);
        bus_rd(12'h000, v); chk("R7 range ctrl", v, cw(16'h0, 0, 1, 0, 8'hC8));

        // R11 refusal while error set
        bus_wr(12'h000, 32'h3E77_000B);
        bus_wr(12'h020, 32'h2);
        chk("R11 prog refused", {31'b0, seq_start}, 32'h0);
        bus_wr(12'h004, 32'h0000_0400);
        chk("R11 reload refused", {31'b0, seq_start}, 32'h0);
        bus_rd(sh(1), v); chk("R11 read zero", v, 32'h0);
        bus_rd(12'h000, v); chk("R11 ctrl", v, cw(16'h3E77, 0, 1, 0, 8'h0B));
        bus_wr(12'h008, 32'hFFFF_0200);
        bus_rd(12'h000, v); chk("R11 cleared", v, cw(16'h0, 0, 0, 0, 8'h0B));

        // R9 read-locked word
        bus_rd(sh(7), v); chk("R9 poison", v, 32'hBADA_BADA);
        bus_rd(12'h000, v); chk("R9 err", v, cw(16'h0, 0, 1, 0, 8'h0B));
        bus_wr(12'h008, 32'h0000_0200);

        // R10 write to program-locked shadow
        bus_wr(sh(5), 32'hDEAD_BEEF);
        bus_rd(12'h000, v); chk("R10 err", v, cw(16'h0, 0, 1, 0, 8'h0B));
        bus_wr(12'h008, 32'h0000_0200);
        bus_rd(sh(5), v); chk("R10 unchanged", v, 32'h0);

        // Random program rounds
        done_wait = 3;
        for (int k = 0; k < 6; k++) begin
            do n = $urandom_range(0, NW-1); while (locked_any(n));
            d = $urandom;
            bus_wr(12'h000, {16'h3E77, 8'h0, 8'(n)});
            bus_wr(12'h020, d);
            chk("R3 rnd start", {31'b0, seq_start}, 32'h1);
            chk("R3 rnd addr", {24'b0, seq_addr}, 32'(n));
            exp_fuse[n] = exp_fuse[n] | d;
            done_check("R8 rnd", cw(16'h0, 0, 0, 1, 8'(n)), cw(16'h0, 0, 0, 0, 8'(n)));
        end

        // R12 refresh, with R10 write during refresh
        done_wait = 5;
        bus_wr(12'h000, 32'h0);
        bus_wr(12'h004, 32'h0000_0400);
        chk("R12 start", {31'b0, seq_start}, 32'h1);
        chk("R12 cmd", {31'b0, seq_cmd}, 32'h1);
        bus_rd(12'h000, v); chk("R12 ctrl", v, cw(16'h0, 1, 0, 1, 8'h0));
        bus_wr(sh(2), 32'h1);
        done_check("R12 done", cw(16'h0, 1, 1, 1, 8'h0), cw(16'h0, 0, 1, 0, 8'h0));
        bus_wr(12'h008, 32'h0000_0200);
        for (int i = 0; i < NW; i++) begin
            if (!read_lock[i]) begin
                bus_rd(sh(i), v); chk("R12 refreshed", v, exp_fuse[i]);
            end
        end

        // R12 fill ignored outside refresh
        @(negedge clk);
        fill_we = 1'b1; fill_idx = 7'd3; fill_data = 32'hFFFF_FFFF;
        @(negedge clk);
        fill_we = 1'b0;
        bus_rd(sh(3), v); chk("R12 fill idle", v, exp_fuse[3]);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule